// File: doc/BRIEF.md
# Two-Slot B-Channel Serial Port

This block carries one 8-bit voice sample per frame across a time-multiplexed serial line of the kind used between ISDN line circuits and codecs. Each frame holds two B-channel slots. A static channel level picks the slot the port uses, for receive and transmit alike. Two slot layouts are supported. In the half-rate layout every data bit spans two cycles of the data clock. In the full-rate layout every bit spans one cycle, and the receive and transmit directions sample on opposite clock edges.

The port runs on a fast core clock. The data clock, the frame sync, the serial input and the two select levels each pass through one register stage. Rising and falling data-clock edges are found by comparing consecutive samples. A state machine steps through each frame with four states: `S_IDLE` before any frame, `S_LEAD` from the frame start up to the selected slot, `S_SLOT` while the slot is being transmitted, and `S_TAIL` from the end of the slot until the next frame.

The named transitions are:
- **start**: on a frame start, go from any state to `S_SLOT` when the slot begins at edge 0, and to `S_LEAD` otherwise.
- **open**: `S_LEAD` goes to `S_SLOT` on the rising edge where the slot begins.
- **close**: `S_SLOT` goes to `S_TAIL` on the first rising edge past the slot.

The serial output and its output enable are meant to drive a three-state pad. The pad releases the line while the enable is low.

Top module: `bslot_serial_port`

## Requirements
- R1: After reset, `sd_oe`, `sd_out`, `rx_valid` and `rx_word` are all 0, and the layout is half-rate.
- R2: `fmt_sel` is sampled at each frame start, with 0 meaning half-rate and 1 meaning full-rate. The layout changes only when the same level is seen at two consecutive frame starts. It takes effect in the frame that begins at the second of those starts. A level seen at a single frame start has no effect.
- R3: `chan_sel` is sampled at each frame start, with 0 meaning the first B slot and 1 meaning the second. It applies to both directions for the whole frame.
- R4: A frame start is a rising `dclk` edge at which `fsync` is 1, given that `fsync` was 0 at the previous rising edge. That edge is numbered 0 and the rising edges after it are numbered 1, 2, and so on. Inputs pass one register stage, and outputs change on the second core-clock edge after the `dclk` change at the pin.
- R5: In the half-rate layout the slot starts at rising edge 0 for the first slot and at rising edge 16 for the second. Bit i (i = 0 is the MSB) is driven on `sd_out` from rising edge start+2i for two data-clock cycles.
- R6: In the full-rate layout the slot starts at rising edge 1 for the first slot and at rising edge 11 for the second. Bit i, MSB first, is driven from rising edge start+i for one data-clock cycle.
- R7: In the half-rate layout, received bit i is taken from `sd_in` at rising edge start+2i+1, which is the middle of the bit.
- R8: In the full-rate layout, received bit i is taken from `sd_in` at the falling edge that follows rising edge start+i.
- R9: `sd_oe` is 1 only from the rising edge where the selected slot starts until the rising edge just past its last bit. It stays 0 during the unused slot and between slots. `sd_out` is 0 whenever `sd_oe` is 0.
- R10: After the eighth received bit, `rx_valid` is 1 for exactly one core clock and `rx_word` shows the received byte, MSB first. `rx_word` holds that value until the next completed slot.
- R11: `tx_word` is sampled at the frame start. Changes to it later in the frame have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk | input | 1 | Serial data clock level |
| fsync | input | 1 | Frame sync level |
| sd_in | input | 1 | Serial receive data |
| fmt_sel | input | 1 | Layout select: 0 half-rate, 1 full-rate |
| chan_sel | input | 1 | Slot select: 0 first B slot, 1 second |
| tx_word | input | BITS | Sample to transmit |
| sd_out | output | 1 | Serial transmit data |
| sd_oe | output | 1 | Output enable for the three-state pad |
| rx_word | output | BITS | Last received sample |
| rx_valid | output | 1 | One-clock strobe for a new `rx_word` |

## Verification
The assertions assume that each `dclk` level lasts at least two core clocks, so that two detected edges never fall on adjacent cycles. They also assume that `fsync`, `sd_in` and the select levels are stable across the core-clock edge that samples a `dclk` transition. The bench keeps within these limits. It holds each data-clock phase for two core clocks, and it changes data and selects only together with a rising `dclk`. The select levels change only at frame starts. Every frame is long enough for the later slot to finish before the next sync arrives.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    typedef enum logic {
        FMT_HALF = 1'b0,
        FMT_FULL = 1'b1
    } fmt_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LEAD = 2'd1,
        S_SLOT = 2'd2,
        S_TAIL = 2'd3
    } slot_st_t;
endpackage

// File: rtl/bsp_edge_sampler.sv
module bsp_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk,
    input  logic fsync,
    input  logic sd_in,
    input  logic fmt_lvl,
    input  logic chan_lvl,
    output logic rise,
    output logic fall,
    output logic frame_start,
    output logic sd_q,
    output logic fmt_q,
    output logic chan_q
);
    logic dclk_q, dclk_qq, fs_q, fs_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_q  <= 1'b0;
            dclk_qq <= 1'b0;
            fs_q    <= 1'b0;
            fs_last <= 1'b0;
            sd_q    <= 1'b0;
            fmt_q   <= 1'b0;
            chan_q  <= 1'b0;
        end else begin
            dclk_q  <= dclk;
            dclk_qq <= dclk_q;
            fs_q    <= fsync;
            sd_q    <= sd_in;
            fmt_q   <= fmt_lvl;
            chan_q  <= chan_lvl;
            if (rise) begin
                fs_last <= fs_q;
            end
        end
    end

    always_comb begin
        rise        = dclk_q & ~dclk_qq;
        fall        = ~dclk_q & dclk_qq;
        frame_start = rise & fs_q & ~fs_last;
    end

    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R4
endmodule

// File: rtl/bsp_fmt_detect.sv
module bsp_fmt_detect
    import bsp_pkg::*;
#(
    parameter int HOLD_FRAMES = 2,
    parameter int STREAK_W    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic fmt_q,
    output fmt_t fmt_new,
    output fmt_t fmt_r
);
    localparam logic [STREAK_W-1:0] STREAK_MAX = {STREAK_W{1'b1}};
    localparam logic [STREAK_W-1:0] HOLD_CNT   = STREAK_W'(HOLD_FRAMES);

    logic [STREAK_W-1:0] streak, streak_nx;
    logic                last_lvl, have_last, same;

    always_comb begin
        same      = have_last && (fmt_q == last_lvl);
        if (!same) begin
            streak_nx = STREAK_W'(1);
        end else if (streak == STREAK_MAX) begin
            streak_nx = STREAK_MAX;
        end else begin
            streak_nx = streak + STREAK_W'(1);
        end
        fmt_new = (streak_nx >= HOLD_CNT) ? fmt_t'(fmt_q) : fmt_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak    <= '0;
            last_lvl  <= 1'b0;
            have_last <= 1'b0;
            fmt_r     <= FMT_HALF;
        end else if (frame_start) begin
            streak    <= streak_nx;
            last_lvl  <= fmt_q;
            have_last <= 1'b1;
            fmt_r     <= fmt_new;
        end
    end

    AST_FMT_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(fmt_r)); // R2
    AST_FMT_NEEDS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (fmt_new != fmt_r)) |-> (have_last && fmt_q == last_lvl)); // R2
endmodule

// File: rtl/bsp_slot_ctrl.sv
module bsp_slot_ctrl
    import bsp_pkg::*;
#(
    parameter int BITS    = 8,
    parameter int IDX_W   = 6,
    parameter int HALF_B2 = 16,
    parameter int FULL_B1 = 1,
    parameter int FULL_B2 = 11,
    localparam int BIT_W  = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             frame_start,
    input  fmt_t             fmt_new,
    input  logic             chan_q,
    output logic             in_slot,
    output logic             tx_strobe,
    output logic [BIT_W-1:0] tx_bit,
    output logic             rx_strobe,
    output logic             rx_last
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    slot_st_t         state, state_nx;
    logic [IDX_W-1:0] idx, e_now, start, win_len, rel, relf;
    logic             framed, framed_e, in_win, rx_win_full;
    fmt_t             fmt_r, fmt_e;
    logic             chan_r, chan_e;

    // frame parameters: fresh at a frame start, held otherwise
    always_comb begin
        fmt_e    = frame_start ? fmt_new : fmt_r;
        chan_e   = frame_start ? chan_q  : chan_r;
        framed_e = frame_start | framed;
        if (frame_start) begin
            e_now = '0;
        end else if (idx == IDX_MAX) begin
            e_now = IDX_MAX;
        end else begin
            e_now = idx + IDX_W'(1);
        end
        if (fmt_e == FMT_HALF) begin
            start   = chan_e ? IDX_W'(HALF_B2) : '0;
            win_len = IDX_W'(2 * BITS);
        end else begin
            start   = chan_e ? IDX_W'(FULL_B2) : IDX_W'(FULL_B1);
            win_len = IDX_W'(BITS);
        end
        rel    = e_now - start;
        relf   = idx - start;
        in_win = framed_e && (e_now >= start) && (e_now < start + win_len);
        rx_win_full = framed && (idx >= start) && (idx < start + IDX_W'(BITS));
    end

    // slot timing strobes
    always_comb begin
        tx_strobe = rise && in_win;
        if (fmt_e == FMT_HALF) begin
            tx_bit    = rel[BIT_W:1];
            rx_strobe = rise && in_win && rel[0];
            rx_last   = (rel[BIT_W:1] == BIT_W'(BITS - 1));
        end else begin
            tx_bit    = rel[BIT_W-1:0];
            rx_strobe = fall && rx_win_full;
            rx_last   = (relf[BIT_W-1:0] == BIT_W'(BITS - 1));
        end
    end

    // next-state process
    always_comb begin
        state_nx = state;
        if (frame_start) begin
            state_nx = (start == '0) ? S_SLOT : S_LEAD;   // start
        end else begin
            unique case (state)
                S_IDLE: state_nx = S_IDLE;
                S_LEAD: if (rise && e_now == start) state_nx = S_SLOT;            // open
                S_SLOT: if (rise && e_now == start + win_len) state_nx = S_TAIL;  // close
                S_TAIL: state_nx = S_TAIL;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            idx    <= '0;
            framed <= 1'b0;
            fmt_r  <= FMT_HALF;
            chan_r <= 1'b0;
        end else begin
            state <= state_nx;
            if (frame_start) begin
                idx    <= '0;
                framed <= 1'b1;
                fmt_r  <= fmt_new;
                chan_r <= chan_q;
            end else if (rise && framed && idx != IDX_MAX) begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // output process
    always_comb begin
        in_slot = (state == S_SLOT);
    end

    AST_IDX_CLEARED_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (idx == '0)); // R4
    AST_SLOT_OPENS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_slot) |-> $past(rise)); // R9
endmodule

// File: rtl/bsp_tx_shift.sv
module bsp_tx_shift #(
    parameter int BITS   = 8,
    localparam int BIT_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             frame_start,
    input  logic [BITS-1:0]  tx_word,
    input  logic             tx_strobe,
    input  logic [BIT_W-1:0] tx_bit,
    output logic             txd
);
    logic [BITS-1:0]  hold, word_e;
    logic [BIT_W-1:0] pos;

    always_comb begin
        word_e = frame_start ? tx_word : hold;
        pos    = BIT_W'(BITS - 1) - tx_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            txd  <= 1'b0;
        end else begin
            if (frame_start) begin
                hold <= tx_word;
            end
            if (tx_strobe) begin
                txd <= word_e[pos];
            end else if (rise) begin
                txd <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bsp_rx_shift.sv
module bsp_rx_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_strobe,
    input  logic            rx_last,
    input  logic            sd_q,
    output logic [BITS-1:0] rx_word,
    output logic            rx_valid
);
    logic [BITS-1:0] sh, sh_nx;

    always_comb begin
        sh_nx = {sh[BITS-2:0], sd_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rx_strobe) begin
                sh <= sh_nx;
                if (rx_last) begin
                    rx_word  <= sh_nx;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R10
    AST_WORD_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> rx_valid); // R10
endmodule

// File: rtl/bslot_serial_port.sv
module bslot_serial_port
    import bsp_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int IDX_W       = 6,
    parameter int HALF_B2     = 16,
    parameter int FULL_B1     = 1,
    parameter int FULL_B2     = 11,
    parameter int HOLD_FRAMES = 2,
    parameter int STREAK_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dclk,
    input  logic            fsync,
    input  logic            sd_in,
    input  logic            fmt_sel,
    input  logic            chan_sel,
    input  logic [BITS-1:0] tx_word,
    output logic            sd_out,
    output logic            sd_oe,
    output logic [BITS-1:0] rx_word,
    output logic            rx_valid
);
    localparam int BIT_W = $clog2(BITS);

    logic             rise, fall, frame_start, sd_q, fmt_q, chan_q;
    logic             in_slot, tx_strobe, rx_strobe, rx_last, txd;
    logic [BIT_W-1:0] tx_bit;
    fmt_t             fmt_new, fmt_r;

    bsp_edge_sampler i_sampler (
        .clk(clk), .rst_n(rst_n), .dclk(dclk), .fsync(fsync), .sd_in(sd_in),
        .fmt_lvl(fmt_sel), .chan_lvl(chan_sel), .rise(rise), .fall(fall),
        .frame_start(frame_start), .sd_q(sd_q), .fmt_q(fmt_q), .chan_q(chan_q)
    );

    bsp_fmt_detect #(.HOLD_FRAMES(HOLD_FRAMES), .STREAK_W(STREAK_W)) i_fmt (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fmt_q(fmt_q),
        .fmt_new(fmt_new), .fmt_r(fmt_r)
    );

    bsp_slot_ctrl #(
        .BITS(BITS), .IDX_W(IDX_W), .HALF_B2(HALF_B2),
        .FULL_B1(FULL_B1), .FULL_B2(FULL_B2)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .frame_start(frame_start), .fmt_new(fmt_new), .chan_q(chan_q),
        .in_slot(in_slot), .tx_strobe(tx_strobe), .tx_bit(tx_bit),
        .rx_strobe(rx_strobe), .rx_last(rx_last)
    );

    bsp_tx_shift #(.BITS(BITS)) i_tx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .frame_start(frame_start),
        .tx_word(tx_word), .tx_strobe(tx_strobe), .tx_bit(tx_bit), .txd(txd)
    );

    bsp_rx_shift #(.BITS(BITS)) i_rx (
        .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_last(rx_last),
        .sd_q(sd_q), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always_comb begin
        sd_oe  = in_slot;
        sd_out = txd;
    end

    AST_TX_ZERO_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_slot |-> !txd); // R9
    AST_OE_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_oe) |-> $past(rise)); // R9
    AST_LAYOUT_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && !frame_start) |=> $stable(fmt_r)); // R2
endmodule

// File: tb/test_bslot_serial_port.sv
`timescale 1ns/1ps
module test_bslot_serial_port;
    typedef struct packed {
        logic       oe;
        logic       out;
        logic       valid;
        logic [7:0] rx;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dclk = 1'b0, fsync = 1'b0, sd_in = 1'b0;
    logic       fmt_sel = 1'b0, chan_sel = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       sd_out, sd_oe, rx_valid;
    logic [7:0] rx_word;

    int   checks = 0, errors = 0, cyc = 0, frame_no = 0, cur_fmt = 0;
    int   streak = 0, last_lvl = 0, have_last = 0, ref_fmt = 0;
    exp_t h1 = '0, h2 = '0, tgt = '0;

    always #2 clk = ~clk;

    bslot_serial_port i_bslot_serial_port (
        .clk(clk), .rst_n(rst_n), .dclk(dclk), .fsync(fsync), .sd_in(sd_in),
        .fmt_sel(fmt_sel), .chan_sel(chan_sel), .tx_word(tx_word),
        .sd_out(sd_out), .sd_oe(sd_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most 50000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int got, input int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s frame %0d fmt %0d: got %0h expected %0h",
                     tag, frame_no, cur_fmt, got, want);
        end
    endtask

    // outputs seen now reflect the inputs driven two core clocks earlier (R4)
    task automatic clk_step();
        @(negedge clk);
        chk("R9 R3 oe", int'(sd_oe), int'(h2.oe));
        chk(cur_fmt == 0 ? "R5 R11 out" : "R6 R11 out", int'(sd_out), int'(h2.out));
        chk("R10 valid", int'(rx_valid), int'(h2.valid));
        chk(cur_fmt == 0 ? "R7 rx" : "R8 rx", int'(rx_word), int'(h2.rx));
        h2 = h1;
    endtask

    task automatic commit();
        h1 = tgt;
        tgt.valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            clk_step();
            commit();
        end
    endtask

    task automatic run_frame(input int lvl, input int ch, input logic [7:0] tw,
                             input logic [7:0] rw, input int nedge);
        int st, wlen, fmt, rel, bi;
        logic inw;
        // layout reference (R2): switch on two equal consecutive samples
        if (have_last != 0 && lvl == last_lvl) streak = (streak < 3) ? streak + 1 : 3;
        else streak = 1;
        last_lvl  = lvl;
        have_last = 1;
        if (streak >= 2) ref_fmt = lvl;
        fmt  = ref_fmt;
        st   = (fmt == 0) ? (ch != 0 ? 16 : 0) : (ch != 0 ? 11 : 1);  // R3
        wlen = (fmt == 0) ? 16 : 8;
        frame_no++;
        cur_fmt = fmt;
        for (int k = 0; k < nedge; k++) begin
            rel = k - st;
            inw = (rel >= 0) && (rel < wlen);
            bi  = (fmt == 0) ? rel / 2 : rel;
            clk_step();
            dclk  = 1'b1;
            fsync = (k < ((fmt == 0) ? 2 : 1));   // R4: long sync in half-rate frames
            if (k == 0) begin
                fmt_sel  = lvl[0];
                chan_sel = ch[0];
                tx_word  = tw;
            end
            if (k == 3) tx_word = ~tw;            // R11: late change ignored
            sd_in = inw ? rw[7 - bi] : logic'(k % 2);
            if (inw) begin
                tgt.oe  = 1'b1;
                tgt.out = tw[7 - bi];
            end else begin
                tgt.oe  = 1'b0;
                tgt.out = 1'b0;
            end
            if (fmt == 0 && inw && (rel % 2) == 1 && bi == 7) begin
                tgt.rx    = rw;
                tgt.valid = 1'b1;
            end
            commit();
            clk_step();
            commit();
            clk_step();
            dclk = 1'b0;
            if (fmt == 1 && inw && bi == 7) begin
                tgt.rx    = rw;
                tgt.valid = 1'b1;
            end
            commit();
            clk_step();
            commit();
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe", int'(sd_oe), 0);
        chk("R1 out", int'(sd_out), 0);
        chk("R1 valid", int'(rx_valid), 0);
        chk("R1 rx", int'(rx_word), 0);
        idle(6);
        run_frame(0, 0, 8'hA5, 8'h3C, 34);  // half-rate, first slot
        run_frame(0, 1, 8'h96, 8'hC3, 34);  // half-rate, second slot
        run_frame(1, 0, 8'h81, 8'h7E, 34);  // R2: one high sample keeps half-rate
        run_frame(0, 0, 8'h5A, 8'hE1, 34);
        run_frame(1, 0, 8'h0F, 8'hF0, 34);
        run_frame(1, 0, 8'hC6, 8'h39, 34);  // R2: second high sample selects full-rate
        run_frame(1, 1, 8'h6B, 8'hD4, 34);  // full-rate, second slot
        run_frame(0, 1, 8'hF3, 8'h1E, 34);  // R2: one low sample keeps full-rate
        run_frame(0, 0, 8'h24, 8'hB7, 34);  // back to half-rate
        run_frame(1, 1, 8'hFF, 8'h00, 34);
        run_frame(1, 1, 8'h01, 8'h80, 34);  // full-rate again, second slot
        idle(10);
        summary();
        $finish;
    end
endmodule